// File: doc/BRIEF.md
# Smart-Card T=0 Character Transmitter

This block sends one byte to a smart card as a T=0 character over a single open-drain I/O line. A byte is handed over with a valid/ready handshake, together with three per-character selects: the bit order, the polarity of the data bits, and the polarity of the parity bit. The block then sends a start bit, the eight data bits, an even-parity bit and a two-bit guard time. It drives the line only when it sends a 0, and it leaves the line to the pull-up at all other times.

Timing comes from a tick input that the surrounding logic pulses `TICKS_PER_BIT` times per bit period. During the guard time the block lets go of the line and samples it in the middle of the first guard bit. A card that rejects the character pulls the line low at that point. The block then raises a one-cycle `nack` pulse and adds one more bit time before it accepts the next byte. Deciding whether to send the character again is left to the logic outside the block.

Top module: `sc_t0_tx`

## Requirements
- R1: While reset is held, and after it is released, `tx_ready` is 1, `line_oe` is 0, `line_out` is 1 and `nack` is 0. Asserting reset during a character returns the block to this state.
- R2: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` then stays 0 until the last guard bit ends.
- R3: The start bit follows acceptance directly. It is a 0 that is driven for one bit time (`TICKS_PER_BIT` ticks).
- R4: The eight data bits come next, one per bit time. With `tx_msb_first`=0 bit 0 goes first; with `tx_msb_first`=1 bit 7 goes first.
- R5: With `tx_inverse`=1 each data bit appears on the line as its complement. With `tx_inverse`=0 it appears unchanged.
- R6: The ninth bit after the start bit is the parity bit. Its value makes the count of ones over the eight data bits and the parity bit even. With `tx_par_inv`=1 it is sent complemented.
- R7: `line_oe` is 1 only while the line level being sent (`line_out`) is 0. At all other times the line is released.
- R8: The guard time is two bit times with the line released. When no error is seen, `tx_ready` returns to 1 exactly 12 bit times after acceptance.
- R9: If the synchronised line is low at tick `TICKS_PER_BIT/2` of the first guard bit, `nack` pulses for exactly one cycle, and `tx_ready` returns 13 bit times after acceptance.
- R10: A low line at any other point of the guard time, such as in the second guard bit, raises no `nack` and does not make the character longer.
- R11: The byte and the selects are captured at acceptance. Changing them, or holding `tx_valid` high, while a character is in flight has no effect on that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Sub-bit timing enable, `TICKS_PER_BIT` pulses per bit |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Block is idle and will take a byte |
| tx_data | input | 8 | Byte to send |
| tx_msb_first | input | 1 | 1: bit 7 first, 0: bit 0 first |
| tx_inverse | input | 1 | 1: data bits sent complemented |
| tx_par_inv | input | 1 | 1: parity bit sent complemented |
| line_in | input | 1 | Level read back from the I/O line |
| line_out | output | 1 | Level being sent; 1 when released |
| line_oe | output | 1 | Output enable of the open-drain pad, active while sending 0 |
| nack | output | 1 | One-cycle pulse when the card signals an error |

## Verification
A wrong bit counter or a wrong index shows up on `line_out` and `line_oe` in the first bit period that uses it: a data bit in the wrong place, a parity bit of the wrong sense, or a line still driven during the guard time. A guard counter that ends the character too soon or too late moves the rise of `tx_ready` by one bit time, and the bench sees that when the character ends. A wrong error sampler is seen through `nack` and the length of the character. This is checked with the card pulling the line during the first guard bit, during the second guard bit, and not at all.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;

  localparam int DATA_BITS  = 8;
  localparam int GUARD_BITS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_GUARD
  } tx_state_e;

endpackage

// File: rtl/sc_t0_bitclk.sv
module sc_t0_bitclk #(
  parameter int TICKS_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic bit_end,
  output logic mid_bit
);

  localparam int CW  = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int MID = TICKS_PER_BIT / 2;

  logic [CW-1:0] sub_q, sub_d;

  assign bit_end = tick && (sub_q == CW'(TICKS_PER_BIT - 1));
  assign mid_bit = tick && (sub_q == CW'(MID));

  always_comb begin
    sub_d = sub_q;
    if (clear || bit_end) begin
      sub_d = '0;
    end else if (tick) begin
      sub_d = sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else begin
      sub_q <= sub_d;
    end
  end

endmodule

// File: rtl/sc_t0_serial.sv
module sc_t0_serial
  import sc_t0_pkg::*;
#(
  localparam int IW = $clog2(DATA_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 msb_first,
  input  logic                 inverse,
  input  logic                 par_inv,
  input  logic [IW-1:0]        idx,
  output logic                 data_lvl,
  output logic                 par_lvl
);

  logic [DATA_BITS-1:0] data_q;
  logic                 msb_q, inv_q, pinv_q;
  logic [DATA_BITS-1:0] rev;
  logic [DATA_BITS-1:0] order;

  for (genvar g = 0; g < DATA_BITS; g++) begin : g_rev
    assign rev[g] = data_q[DATA_BITS-1-g];
  end

  assign order    = msb_q ? rev : data_q;
  assign data_lvl = order[idx] ^ inv_q;
  assign par_lvl  = (^data_q) ^ pinv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      msb_q  <= 1'b0;
      inv_q  <= 1'b0;
      pinv_q <= 1'b0;
    end else if (load) begin
      data_q <= data;
      msb_q  <= msb_first;
      inv_q  <= inverse;
      pinv_q <= par_inv;
    end
  end

endmodule

// File: rtl/sc_t0_ctrl.sv
module sc_t0_ctrl
  import sc_t0_pkg::*;
#(
  localparam int IW = $clog2(DATA_BITS),
  localparam int GW = $clog2(GUARD_BITS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_valid,
  input  logic          bit_end,
  input  logic          mid_bit,
  input  logic          line_sync,
  input  logic          data_lvl,
  input  logic          par_lvl,
  output logic          ready,
  output logic          load,
  output logic [IW-1:0] idx,
  output logic          line_out,
  output logic          line_oe,
  output logic          nack
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

  tx_state_e     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          err_q, err_d;
  logic          nack_q, nack_d;
  logic [GW-1:0] guard_last;

  assign ready      = (state_q == ST_IDLE);
  assign load       = ready && tx_valid;
  assign idx        = idx_q;
  assign nack       = nack_q;
  assign guard_last = err_q ? GW'(GUARD_BITS) : GW'(GUARD_BITS - 1);

  always_comb begin
    unique case (state_q)
      ST_START:  line_out = 1'b0;
      ST_DATA:   line_out = data_lvl;
      ST_PARITY: line_out = par_lvl;
      default:   line_out = 1'b1;
    endcase
    line_oe = !line_out;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    gcnt_d  = gcnt_q;
    err_d   = err_q;
    nack_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_valid) begin
          state_d = ST_START;
        end
      end
      ST_START: begin
        if (bit_end) begin
          state_d = ST_DATA;
          idx_d   = '0;
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_PARITY;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (bit_end) begin
          state_d = ST_GUARD;
          gcnt_d  = '0;
          err_d   = 1'b0;
        end
      end
      ST_GUARD: begin
        if (mid_bit && (gcnt_q == '0) && !line_sync) begin
          err_d  = 1'b1;
          nack_d = 1'b1;
        end
        if (bit_end) begin
          if (gcnt_q == guard_last) begin
            state_d = ST_IDLE;
          end else begin
            gcnt_d = gcnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      gcnt_q  <= '0;
      err_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      gcnt_q  <= gcnt_d;
      err_q   <= err_d;
      nack_q  <= nack_d;
    end
  end

  AST_OE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> !line_out); // R7

  AST_START_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && ready) |=> (line_oe && !line_out && !ready)); // R3

  AST_NACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nack |=> !nack); // R9

  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> (!line_oe && !ready)); // R9

  AST_DONE_ON_BIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(bit_end)); // R8

endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
  import sc_t0_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_msb_first,
  input  logic                 tx_inverse,
  input  logic                 tx_par_inv,
  input  logic                 line_in,
  output logic                 line_out,
  output logic                 line_oe,
  output logic                 nack
);

  localparam int IW = $clog2(DATA_BITS);

  logic [1:0]    rst_pipe;
  logic          rst_ns;
  logic [1:0]    line_pipe;
  logic          bit_end, mid_bit, load, data_lvl, par_lvl;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ns = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      line_pipe <= 2'b11;
    end else begin
      line_pipe <= {line_pipe[0], line_in};
    end
  end

  sc_t0_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_bitclk (
    .clk     (clk),
    .rst_n   (rst_ns),
    .tick    (tick),
    .clear   (load),
    .bit_end (bit_end),
    .mid_bit (mid_bit)
  );

  sc_t0_serial i_serial (
    .clk       (clk),
    .rst_n     (rst_ns),
    .load      (load),
    .data      (tx_data),
    .msb_first (tx_msb_first),
    .inverse   (tx_inverse),
    .par_inv   (tx_par_inv),
    .idx       (idx),
    .data_lvl  (data_lvl),
    .par_lvl   (par_lvl)
  );

  sc_t0_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .tx_valid  (tx_valid),
    .bit_end   (bit_end),
    .mid_bit   (mid_bit),
    .line_sync (line_pipe[1]),
    .data_lvl  (data_lvl),
    .par_lvl   (par_lvl),
    .ready     (tx_ready),
    .load      (load),
    .idx       (idx),
    .line_out  (line_out),
    .line_oe   (line_oe),
    .nack      (nack)
  );

endmodule

// File: tb/test_sc_t0_tx.sv
module test_sc_t0_tx;

  localparam int TPB = 4;

  logic       clk = 1'b0;
  logic       rst_n, tick, tx_valid, tx_msb_first, tx_inverse, tx_par_inv;
  logic [7:0] tx_data;
  logic       card_pull;
  logic       line_in;
  logic       tx_ready, line_out, line_oe, nack;

  int checks = 0;
  int fails  = 0;
  int nack_cnt = 0;

  always #2.5 clk = ~clk;

  assign line_in = !(line_oe || card_pull);

  always @(posedge clk) if (nack) nack_cnt++;

  sc_t0_tx #(.TICKS_PER_BIT(TPB)) i_sc_t0_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_msb_first(tx_msb_first), .tx_inverse(tx_inverse), .tx_par_inv(tx_par_inv),
    .line_in(line_in), .line_out(line_out), .line_oe(line_oe), .nack(nack)
  );

  // {pull_mode[1:0], par_inv, inverse, msb_first, data[7:0]}
  // pull_mode: 0 none, 1 card pulls in guard bit 1, 2 card pulls in guard bit 2
  localparam logic [12:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'h3C},
    {2'd0, 1'b0, 1'b1, 1'b0, 8'h01},
    {2'd0, 1'b1, 1'b1, 1'b1, 8'h80},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 1'b1, 1'b0, 8'h00},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'h5A},
    {2'd1, 1'b0, 1'b1, 1'b0, 8'hC3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic msb, input logic inv,
                      input logic pinv, input int mode, input bit hold);
    int  nb;
    logic lvl;
    logic p;
    nb = (mode == 1) ? 13 : 12;
    p  = ^d;
    nack_cnt = 0;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_msb_first = msb; tx_inverse = inv; tx_par_inv = pinv;
    @(negedge clk);
    if (hold) begin
      tx_data = ~d; tx_msb_first = ~msb; tx_inverse = ~inv; tx_par_inv = ~pinv;
    end else begin
      tx_valid = 1'b0;
    end
    for (int k = 0; k < nb; k++) begin
      if (k == 0) lvl = 1'b0;
      else if (k <= 8) lvl = (msb ? d[8-k] : d[k-1]) ^ inv;
      else if (k == 9) lvl = p ^ pinv;
      else lvl = 1'b1;
      if (k == 0)       chk(line_out == lvl && line_oe == 1'b1, "R3 start bit", {line_oe, line_out}, 2'b10);
      else if (k <= 8)  chk(line_out == lvl, hold ? "R11 R4 R5 data bit" : "R4 R5 data bit", line_out, lvl);
      else if (k == 9)  chk(line_out == lvl, "R6 parity bit", line_out, lvl);
      else              chk(line_out == 1'b1 && line_oe == 1'b0, "R8 guard released", {line_oe, line_out}, 2'b01);
      chk(line_oe == !line_out, "R7 drive only low", line_oe, !line_out);
      chk(tx_ready == 1'b0, "R2 busy", tx_ready, 0);
      card_pull = (mode == 1 && k == 10) || (mode == 2 && k == 11);
      if (hold && k == nb - 1) tx_valid = 1'b0;
      repeat (TPB) do_tick();
      card_pull = 1'b0;
    end
    chk(tx_ready == 1'b1, mode == 1 ? "R9 length 13" : "R8 R10 length 12", tx_ready, 1);
    chk(nack_cnt == ((mode == 1) ? 1 : 0), mode == 2 ? "R10 late pull" : "R9 nack count",
        nack_cnt, (mode == 1) ? 1 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
    tx_msb_first = 1'b0; tx_inverse = 1'b0; tx_par_inv = 1'b0; card_pull = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_ready && !line_oe && line_out && !nack, "R1 in reset",
        {tx_ready, line_oe, line_out, nack}, 4'b1010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_ready && !line_oe && line_out && !nack, "R1 after reset",
        {tx_ready, line_oe, line_out, nack}, 4'b1010);

    for (int v = 0; v < 8; v++) begin
      send(VEC[v][7:0], VEC[v][8], VEC[v][9], VEC[v][10], int'(VEC[v][12:11]), 1'b0);
    end

    // R11: valid held high and inputs changed while busy
    send(8'h96, 1'b1, 1'b0, 1'b1, 0, 1'b1);

    // R1: reset during a character
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 8'h00;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (3 * TPB) do_tick();
    rst_n = 1'b0;
    @(negedge clk);
    chk(tx_ready && !line_oe && line_out, "R1 mid-frame reset",
        {tx_ready, line_oe, line_out}, 3'b101);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h7E, 1'b0, 1'b0, 1'b0, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule